// File: doc/BRIEF.md
# Masked Associative Memory

This block is a small content-addressed store of DEPTH cells. Each cell keeps a WIDTH-bit data word and one occupancy flag. The caller presents a key and a per-bit mask, and the block compares them with every cell in the same cycle. It returns a vector of hitting cells, the number of hits, and a three-way multiplicity summary: no hit, a single hit, or several hits. Only key bits whose mask bit is 1 take part in the comparison.

A read runs the same comparison. It then returns the word held in the lowest-numbered hitting cell, or it cancels when nothing hits. A write needs no address. The block finds room by running an ordinary masked comparison against the occupancy flag alone: flag value 0, flag bit unmasked, every data bit masked out. The word then goes into the lowest-numbered free cell. When no cell is free, the write is refused and flagged. The hit count lets the caller learn how many cells satisfy a query without reading any word out. All outputs are registered, and every operation finishes in one clock.

Top module: `assoc_cam_top`

## Requirements
- R1: An active-low `rst_n` clears every occupancy flag. It also sets `hit_vec_o`=0, `hit_count_o`=0, `none_o`=1, `one_o`=0, `many_o`=0, `rdata_o`=0, and `done_o`, `rd_valid_o` and `full_err_o` to 0.
- R2: On a search or a read, data bit i takes part in the comparison only when `mask_i[i]`=1. A masked-out bit never changes the result.
- R3: After a search or a read, `hit_vec_o[j]` is 1 exactly when cell j is occupied and agrees with `key_i` on every unmasked bit. `op_kind_i` encodes the operation: 2'b00 search, 2'b01 read, 2'b10 write, 2'b11 search.
- R4: `hit_count_o` equals the number of 1 bits in the reported hit vector.
- R5: Exactly one of `none_o`, `one_o` and `many_o` is 1. They mean zero hits, one hit, and two or more hits.
- R6: A free cell never hits a search or a read, whatever the key and mask are. A mask of all zeros therefore hits exactly the occupied cells.
- R7: A read with no hit gives `rd_valid_o`=0 and `rdata_o`=0. Otherwise it gives `rd_valid_o`=1 and `rdata_o` equal to the word in the lowest-numbered hitting cell. A search leaves `rdata_o` unchanged.
- R8: A write reports the free-cell vector in `hit_vec_o`, with bit j=1 when cell j is free. The count and summary of that vector are reported with it. `wdata_i` is stored in the lowest-numbered free cell, and that cell becomes occupied.
- R9: A write when no cell is free sets `full_err_o`=1 for that result and changes no cell and no flag.
- R10: The result of an operation accepted with `op_valid_i`=1 appears on the outputs after the next rising edge, with `done_o`=1. In a cycle with no operation, `done_o`, `rd_valid_o` and `full_err_o` return to 0, and the other outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation request this cycle |
| op_kind_i | input | 2 | 00 search, 01 read, 10 write, 11 search |
| key_i | input | WIDTH | Comparison key |
| mask_i | input | WIDTH | Per-bit compare enable |
| wdata_i | input | WIDTH | Word to store on a write |
| done_o | output | 1 | Result of an operation is present |
| hit_vec_o | output | DEPTH | Per-cell hit vector |
| none_o | output | 1 | No cell hit |
| one_o | output | 1 | Exactly one cell hit |
| many_o | output | 1 | Two or more cells hit |
| hit_count_o | output | $clog2(DEPTH+1) | Number of hits |
| rd_valid_o | output | 1 | Read found a word |
| rdata_o | output | WIDTH | Word from the lowest hitting cell |
| full_err_o | output | 1 | Write refused, no free cell |

## Verification
The bench builds the block with DEPTH=6 and WIDTH=5. Six cells fill after six writes, so the refused-write path comes up many times in every random stretch. A 5-bit word space drawn from a handful of values makes duplicate contents common, so the many-hit summary and the pick of the lowest-numbered cell get regular use. Resets between random rounds give the fill sequence again from an empty array, with mask patterns that range from full compares to all-masked queries.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [1:0] {
    OP_SEARCH     = 2'b00,
    OP_READ       = 2'b01,
    OP_WRITE      = 2'b10,
    OP_SEARCH_ALT = 2'b11
  } cam_op_e;

  typedef struct packed {
    logic none;
    logic one;
    logic many;
  } cam_mult_t;

endpackage

// File: rtl/cam_cell_cmp.sv
module cam_cell_cmp #(
  parameter int WIDTH = 8
) (
  input  logic             cell_occ,
  input  logic [WIDTH-1:0] cell_data,
  input  logic             q_flag,
  input  logic             q_flag_en,
  input  logic [WIDTH-1:0] q_key,
  input  logic [WIDTH-1:0] q_mask,
  output logic             hit
);

  localparam int FULL_W = WIDTH + 1;

  logic [FULL_W-1:0] stored;
  logic [FULL_W-1:0] probe;
  logic [FULL_W-1:0] enable;
  logic [FULL_W-1:0] differ;

  always_comb begin
    stored = {cell_occ, cell_data};
    probe  = {q_flag, q_key};
    enable = {q_flag_en, q_mask};
    differ = (stored ^ probe) & enable;
    hit    = ~|differ;
  end

endmodule

// File: rtl/cam_hit_resolver.sv
module cam_hit_resolver #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]  vec_i,
  output logic [DEPTH-1:0]  first_oh_o,
  output logic [CNT_W-1:0]  count_o,
  output cam_pkg::cam_mult_t mult_o
);

  logic [CNT_W-1:0] tally;

  always_comb begin
    first_oh_o = vec_i & (~vec_i + DEPTH'(1));
  end

  always_comb begin
    tally = '0;
    for (int j = 0; j < DEPTH; j++) begin
      tally = tally + CNT_W'(vec_i[j]);
    end
  end

  always_comb begin
    count_o     = tally;
    mult_o.none = (tally == '0);
    mult_o.one  = (tally == CNT_W'(1));
    mult_o.many = !mult_o.none && !mult_o.one;
  end

endmodule

// File: rtl/cam_store.sv
module cam_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [DEPTH-1:0]            wr_sel,
  input  logic [WIDTH-1:0]            wr_data,
  input  logic [DEPTH-1:0]            rd_sel,
  output logic [DEPTH-1:0]            occ_o,
  output logic [DEPTH-1:0][WIDTH-1:0] cells_o,
  output logic [WIDTH-1:0]            rd_data_o
);

  logic [DEPTH-1:0]            occ_q;
  logic [DEPTH-1:0]            occ_d;
  logic [DEPTH-1:0][WIDTH-1:0] cells_q;
  logic [DEPTH-1:0]            cell_we;

  always_comb begin
    cell_we = wr_en ? wr_sel : '0;
    occ_d   = occ_q | cell_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else if (wr_en) begin
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < DEPTH; j++) begin
      if (cell_we[j]) begin
        cells_q[j] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (rd_sel[j]) begin
        rd_data_o = rd_data_o | cells_q[j];
      end
    end
  end

  assign occ_o   = occ_q;
  assign cells_o = cells_q;

endmodule

// File: rtl/assoc_cam_top.sv
module assoc_cam_top #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid_i,
  input  logic [1:0]       op_kind_i,
  input  logic [WIDTH-1:0] key_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             done_o,
  output logic [DEPTH-1:0] hit_vec_o,
  output logic             none_o,
  output logic             one_o,
  output logic             many_o,
  output logic [CNT_W-1:0] hit_count_o,
  output logic             rd_valid_o,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_err_o
);

  import cam_pkg::*;

  cam_op_e                     kind;
  logic                        kind_write;
  logic                        kind_read;
  logic                        q_flag;
  logic [WIDTH-1:0]            q_key;
  logic [WIDTH-1:0]            q_mask;
  logic [DEPTH-1:0]            occ;
  logic [DEPTH-1:0][WIDTH-1:0] cells;
  logic [DEPTH-1:0]            row_hit;
  logic [DEPTH-1:0]            first_oh;
  logic [CNT_W-1:0]            count;
  cam_mult_t                   mult;
  logic [WIDTH-1:0]            sel_word;
  logic                        store_we;

  // Query formation: a write becomes a search for a clear flag.
  always_comb begin
    kind       = cam_op_e'(op_kind_i);
    kind_write = (kind == OP_WRITE);
    kind_read  = (kind == OP_READ);
    q_flag     = !kind_write;
    q_key      = kind_write ? '0 : key_i;
    q_mask     = kind_write ? '0 : mask_i;
    store_we   = op_valid_i && kind_write && !mult.none;
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_row
    cam_cell_cmp #(
      .WIDTH(WIDTH)
    ) cmp_i (
      .cell_occ (occ[j]),
      .cell_data(cells[j]),
      .q_flag   (q_flag),
      .q_flag_en(1'b1),
      .q_key    (q_key),
      .q_mask   (q_mask),
      .hit      (row_hit[j])
    );
  end

  cam_hit_resolver #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
  ) res_i (
    .vec_i     (row_hit),
    .first_oh_o(first_oh),
    .count_o   (count),
    .mult_o    (mult)
  );

  cam_store #(
    .DEPTH(DEPTH),
    .WIDTH(WIDTH)
  ) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (store_we),
    .wr_sel   (first_oh),
    .wr_data  (wdata_i),
    .rd_sel   (first_oh),
    .occ_o    (occ),
    .cells_o  (cells),
    .rd_data_o(sel_word)
  );

  // Next-state for the registered result.
  logic             done_d;
  logic [DEPTH-1:0] hit_vec_d;
  cam_mult_t        mult_d;
  logic [CNT_W-1:0] count_d;
  logic             rd_valid_d;
  logic [WIDTH-1:0] rdata_d;
  logic             full_err_d;
  cam_mult_t        mult_q;

  always_comb begin
    done_d     = op_valid_i;
    hit_vec_d  = hit_vec_o;
    mult_d     = mult_q;
    count_d    = hit_count_o;
    rdata_d    = rdata_o;
    rd_valid_d = 1'b0;
    full_err_d = 1'b0;
    if (op_valid_i) begin
      hit_vec_d  = row_hit;
      mult_d     = mult;
      count_d    = count;
      full_err_d = kind_write && mult.none;
      if (kind_read) begin
        rd_valid_d = !mult.none;
        rdata_d    = mult.none ? '0 : sel_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      hit_vec_o   <= '0;
      mult_q      <= '{none: 1'b1, one: 1'b0, many: 1'b0};
      hit_count_o <= '0;
      rd_valid_o  <= 1'b0;
      rdata_o     <= '0;
      full_err_o  <= 1'b0;
    end else begin
      done_o      <= done_d;
      hit_vec_o   <= hit_vec_d;
      mult_q      <= mult_d;
      hit_count_o <= count_d;
      rd_valid_o  <= rd_valid_d;
      rdata_o     <= rdata_d;
      full_err_o  <= full_err_d;
    end
  end

  assign none_o = mult_q.none;
  assign one_o  = mult_q.one;
  assign many_o = mult_q.many;

endmodule

// File: rtl/assoc_cam_chk.sv
module assoc_cam_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid_i,
  input logic [1:0]       op_kind_i,
  input logic             done_o,
  input logic [DEPTH-1:0] hit_vec_o,
  input logic             none_o,
  input logic             one_o,
  input logic             many_o,
  input logic [CNT_W-1:0] hit_count_o,
  input logic             rd_valid_o,
  input logic [WIDTH-1:0] rdata_o,
  input logic             full_err_o
);

  a_r5_single_summary: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({none_o, one_o, many_o}) == 1);

  a_r4_count_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count_o == CNT_W'($countones(hit_vec_o)));

  a_r5_none_means_empty_vec: assert property (@(posedge clk) disable iff (!rst_n)
    none_o == (hit_vec_o == '0));

  a_r7_read_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> !none_o);

  a_r7_cancelled_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !rd_valid_o && $past(op_kind_i) == 2'b01) |-> rdata_o == '0);

  a_r9_full_only_without_free: assert property (@(posedge clk) disable iff (!rst_n)
    full_err_o |-> none_o);

  a_r10_done_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i |=> done_o);

  a_r10_idle_clears_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> (!done_o && !rd_valid_o && !full_err_o));

endmodule

bind assoc_cam_top assoc_cam_chk #(
  .DEPTH(DEPTH),
  .WIDTH(WIDTH),
  .CNT_W(CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid_i (op_valid_i),
  .op_kind_i  (op_kind_i),
  .done_o     (done_o),
  .hit_vec_o  (hit_vec_o),
  .none_o     (none_o),
  .one_o      (one_o),
  .many_o     (many_o),
  .hit_count_o(hit_count_o),
  .rd_valid_o (rd_valid_o),
  .rdata_o    (rdata_o),
  .full_err_o (full_err_o)
);

// File: tb/assoc_cam_top_tb_top.sv
module assoc_cam_top_tb_top;

  localparam int DEPTH = 6;
  localparam int WIDTH = 5;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int WATCHDOG = 150000;

  logic             clk;
  logic             rst_n;
  logic             op_valid_i;
  logic [1:0]       op_kind_i;
  logic [WIDTH-1:0] key_i;
  logic [WIDTH-1:0] mask_i;
  logic [WIDTH-1:0] wdata_i;
  logic             done_o;
  logic [DEPTH-1:0] hit_vec_o;
  logic             none_o;
  logic             one_o;
  logic             many_o;
  logic [CNT_W-1:0] hit_count_o;
  logic             rd_valid_o;
  logic [WIDTH-1:0] rdata_o;
  logic             full_err_o;

  assoc_cam_top #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_kind_i(op_kind_i),
    .key_i(key_i), .mask_i(mask_i), .wdata_i(wdata_i), .done_o(done_o),
    .hit_vec_o(hit_vec_o), .none_o(none_o), .one_o(one_o), .many_o(many_o),
    .hit_count_o(hit_count_o), .rd_valid_o(rd_valid_o), .rdata_o(rdata_o),
    .full_err_o(full_err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Behavioural reference state.
  bit            m_occ [DEPTH];
  int            m_data[DEPTH];
  int            e_hit;
  int            e_cnt;
  bit            e_none, e_one, e_many, e_done, e_rdv, e_full;
  int            e_rdata;

  task automatic model_reset();
    for (int j = 0; j < DEPTH; j++) m_occ[j] = 0;
    e_hit = 0; e_cnt = 0; e_none = 1; e_one = 0; e_many = 0;
    e_done = 0; e_rdv = 0; e_full = 0; e_rdata = 0;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic compare(string ctx);
    chk({"R3 ", ctx}, "hit_vec", int'(hit_vec_o), e_hit);
    chk({"R4 ", ctx}, "count", int'(hit_count_o), e_cnt);
    chk({"R5 ", ctx}, "summary", int'({none_o, one_o, many_o}), int'({e_none, e_one, e_many}));
    chk({"R7 ", ctx}, "rd_valid", int'(rd_valid_o), int'(e_rdv));
    chk({"R7 ", ctx}, "rdata", int'(rdata_o), e_rdata);
    chk({"R9 ", ctx}, "full_err", int'(full_err_o), int'(e_full));
    chk({"R10 ", ctx}, "done", int'(done_o), int'(e_done));
  endtask

  task automatic set_summary(int v);
    int c = 0;
    for (int j = 0; j < DEPTH; j++) if (v[j]) c++;
    e_hit = v; e_cnt = c;
    e_none = (c == 0); e_one = (c == 1); e_many = (c > 1);
  endtask

  task automatic model_op(bit valid, int kind, int key, int msk, int wd);
    int v = 0;
    int low = -1;
    e_done = valid; e_rdv = 0; e_full = 0;
    if (!valid) return;
    if (kind == 2) begin
      for (int j = 0; j < DEPTH; j++) if (!m_occ[j]) v |= (1 << j);
      set_summary(v);
      for (int j = DEPTH - 1; j >= 0; j--) if (!m_occ[j]) low = j;
      if (low < 0) e_full = 1;
      else begin m_occ[low] = 1; m_data[low] = wd; end
    end else begin
      for (int j = 0; j < DEPTH; j++)
        if (m_occ[j] && (((m_data[j] ^ key) & msk) == 0)) v |= (1 << j);
      set_summary(v);
      if (kind == 1) begin
        for (int j = DEPTH - 1; j >= 0; j--) if (v[j]) low = j;
        e_rdv   = (low >= 0);
        e_rdata = (low >= 0) ? m_data[low] : 0;
      end
    end
  endtask

  // One clock: check the result of the previous cycle, then drive the next.
  task automatic step(string ctx, bit valid, int kind, int key, int msk, int wd);
    @(negedge clk);
    compare(ctx);
    op_valid_i = valid;
    op_kind_i  = kind[1:0];
    key_i      = key[WIDTH-1:0];
    mask_i     = msk[WIDTH-1:0];
    wdata_i    = wd[WIDTH-1:0];
    model_op(valid, kind, key, msk, wd);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    compare("pre-reset");
    rst_n = 1'b0;
    op_valid_i = 1'b0;
    model_reset();
    @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
  endtask

  localparam int FULLM = (1 << WIDTH) - 1;

  initial begin
    rst_n = 1'b0; op_valid_i = 1'b0; op_kind_i = '0;
    key_i = '0; mask_i = '0; wdata_i = '0;
    model_reset();
    repeat (2) begin
      @(negedge clk);
      compare("R1 reset values");
    end
    rst_n = 1'b1;
    // R6: empty array, full mask and empty mask both give no hit.
    step("R1 idle", 0, 0, 0, 0, 0);
    step("R6 empty", 1, 0, 0, FULLM, 0);
    step("R6 empty mask0", 1, 0, 0, 0, 0);
    step("R7 read empty", 1, 1, 0, 0, 0);
    // R8: fill with duplicates.
    step("R8 wr", 1, 2, 0, 0, 3);
    step("R8 wr", 1, 2, 0, 0, 5);
    step("R8 wr", 1, 2, 0, 0, 3);
    step("R8 wr", 1, 2, 0, 0, 12);
    step("R8 wr", 1, 2, 0, 0, 7);
    step("R8 wr", 1, 2, 0, 0, 3);
    step("R9 full", 1, 2, 0, 0, 31);
    step("R9 unchanged", 1, 0, 0, 0, 0);
    step("R7 many lowest", 1, 1, 3, FULLM, 0);
    step("R7 single", 1, 1, 12, FULLM, 0);
    step("R2 masked low bits", 1, 0, 4, 5'b11100, 0);
    step("R2 masked search", 1, 3, 1, 5'b00001, 0);
    step("R7 read miss", 1, 1, 9, FULLM, 0);
    step("R10 idle hold", 0, 0, 0, 0, 0);
    step("R10 idle hold", 0, 1, 3, FULLM, 0);
    // Random rounds with resets between them.
    for (int r = 0; r < 40; r++) begin
      apply_reset();
      for (int k = 0; k < 120; k++) begin
        int kind = $urandom_range(0, 3);
        int key  = $urandom_range(0, 7);
        int msk  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, FULLM)) : FULLM;
        int wd   = $urandom_range(0, 7);
        bit vld  = ($urandom_range(0, 5) != 0);
        step("random", vld, kind, key, msk, wd);
      end
    end
    step("final", 0, 0, 0, 0, 0);
    step("final", 0, 0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule